// File: doc/BRIEF.md
# Controller Time Base and Strobe Generator

This block is the timing heart of a sampled digital controller. A free-running ramp counter advances once per system clock and restarts after a programmable number of cycles. The counter value goes out on a port so that pulse-width modulators can use it as their common carrier reference. From the same counter the block derives three single-cycle strobes:

- a sample strobe that fires once per ramp period, at a programmable offset inside it;
- an interrupt strobe that keeps one of every N sample strobes;
- an end-of-task strobe that follows each sample strobe after a programmable delay.

The delay represents the time from acquisition until the controller's results are ready. That time is the converter latency, the computation time and the transfer time summed together.

All settings arrive on plain parallel inputs and are counted in system clock cycles. The block takes a new setting in only while it is in reset or on the cycle in which the ramp restarts. A ramp period therefore never mixes two settings. Settings that fall outside their legal range are mapped onto the nearest meaningful value, so the block needs no error reporting.

Top module: `tmg_timebase`

## Requirements
- R1: `ramp_o` counts 0, 1, …, P−1 and then returns to 0, advancing once per clock, where P is the active period setting. A period setting of 0 acts as 1, and the ramp then stays at 0.
- R2: `sample_stb_o` is high for exactly the clock cycle that follows each cycle in which `ramp_o` equals the active phase. Its rate is therefore one pulse per ramp period.
- R3: A phase setting greater than or equal to the effective period is used as period−1.
- R4: `irq_stb_o` fires on the first sample strobe after reset and then on every K-th sample strobe, where K is the postscaler setting. A setting of 0 acts as 1, which makes the interrupt fire on every sample strobe.
- R5: `irq_stb_o` is never high in a cycle where `sample_stb_o` is low.
- R6: `task_done_stb_o` goes high D cycles after each sample strobe, where D is the delay setting. With D = 0 it coincides with the sample strobe.
- R7: Each sample strobe restarts any delay countdown still pending. When D is greater than or equal to the period, `task_done_stb_o` therefore never fires.
- R8: Changes on the configuration inputs take effect only in the cycle after the ramp shows its last value P−1, or while reset is held. A period change made mid-ramp lets the current ramp run to its old end.
- R9: While `rst` is high, and in the first cycle after it, `ramp_o` is 0 and all three strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_period | input | CW | Ramp period in clock cycles |
| cfg_phase | input | CW | Sample offset within the ramp period |
| cfg_post | input | PW | Interrupt postscaler |
| cfg_delay | input | DW | Sample-to-end-of-task delay in cycles |
| ramp_o | output | CW | Ramp counter value for modulators |
| sample_stb_o | output | 1 | Sample strobe |
| irq_stb_o | output | 1 | Interrupt strobe |
| task_done_stb_o | output | 1 | End-of-task strobe |

## Verification
The assertions assume that the configuration inputs carry defined values whenever reset is low. They also assume that reset is applied for at least one clock before any check is relied on. They place no limit on the values themselves, because the block maps out-of-range periods, phases and postscalers to legal ones. The stimulus changes its settings only at falling edges. It pulses reset before each new combination, except in one case, which moves the period mid-ramp on purpose to show that the change is deferred to the restart.

// File: rtl/tmg_pkg.sv
package tmg_pkg;

    // Strobe bundle registered at the block's output
    typedef struct packed {
        logic sample;
        logic irq;
        logic done;
    } tmg_strobe_t;

    localparam tmg_strobe_t TMG_STROBE_IDLE = '{sample: 1'b0, irq: 1'b0, done: 1'b0};

endpackage

// File: rtl/tmg_cfg_latch.sv
module tmg_cfg_latch #(
    parameter int CW = 16,
    parameter int PW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_phase,
    input  logic [PW-1:0] cfg_post,
    input  logic [DW-1:0] cfg_delay,
    output logic [CW-1:0] per_q,
    output logic [CW-1:0] ph_q,
    output logic [PW-1:0] post_q,
    output logic [DW-1:0] dly_q
);
    logic [CW-1:0] per_eff;
    logic [CW-1:0] ph_eff;
    logic [PW-1:0] post_eff;

    // Map illegal settings to the nearest meaningful value
    always_comb begin
        per_eff  = (cfg_period == '0) ? CW'(1) : cfg_period;
        ph_eff   = (cfg_phase >= per_eff) ? (per_eff - CW'(1)) : cfg_phase;
        post_eff = (cfg_post == '0) ? PW'(1) : cfg_post;
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            per_q  <= per_eff;
            ph_q   <= ph_eff;
            post_q <= post_eff;
            dly_q  <= cfg_delay;
        end
    end
endmodule

// File: rtl/tmg_base_ctr.sv
module tmg_base_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] per_q,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    // per_q is never zero, so per_q-1 is the last ramp value
    assign wrap = (cnt >= (per_q - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst || wrap)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end
endmodule

// File: rtl/tmg_postscale.sv
module tmg_postscale #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic [PW-1:0] post_q,
    output logic          irq_hit
);
    logic [PW-1:0] pcnt;
    logic [PW:0]   pnext;

    assign pnext   = {1'b0, pcnt} + (PW+1)'(1);
    assign irq_hit = evt && (pcnt == '0);

    always_ff @(posedge clk) begin
        if (rst)
            pcnt <= '0;
        else if (evt)
            pcnt <= (pnext >= {1'b0, post_q}) ? '0 : pnext[PW-1:0];
    end
endmodule

// File: rtl/tmg_delay.sv
module tmg_delay #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt,
    input  logic [DW-1:0] dly_q,
    output logic          done_hit
);
    logic [DW-1:0] rem;
    logic          busy;

    // A fresh sample event overrides a countdown about to expire
    assign done_hit = evt ? (dly_q == '0) : (busy && (rem == DW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            busy <= 1'b0;
        end else if (evt) begin
            rem  <= dly_q;
            busy <= (dly_q != '0);
        end else if (busy) begin
            rem <= rem - DW'(1);
            if (rem == DW'(1))
                busy <= 1'b0;
        end
    end
endmodule

// File: rtl/tmg_timebase.sv
module tmg_timebase
    import tmg_pkg::*;
#(
    parameter int CW = 16,
    parameter int PW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cfg_period,
    input  logic [CW-1:0] cfg_phase,
    input  logic [PW-1:0] cfg_post,
    input  logic [DW-1:0] cfg_delay,
    output logic [CW-1:0] ramp_o,
    output logic          sample_stb_o,
    output logic          irq_stb_o,
    output logic          task_done_stb_o
);
    logic [CW-1:0] per_q;
    logic [CW-1:0] ph_q;
    logic [PW-1:0] post_q;
    logic [DW-1:0] dly_q;
    logic [CW-1:0] cnt;
    logic          wrap;
    logic          sample_evt;
    logic          irq_hit;
    logic          done_hit;
    tmg_strobe_t   stb_d, stb_q;

    tmg_cfg_latch #(.CW(CW), .PW(PW), .DW(DW)) u_cfg (
        .clk(clk), .rst(rst), .load(wrap),
        .cfg_period(cfg_period), .cfg_phase(cfg_phase),
        .cfg_post(cfg_post), .cfg_delay(cfg_delay),
        .per_q(per_q), .ph_q(ph_q), .post_q(post_q), .dly_q(dly_q)
    );

    tmg_base_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst(rst), .per_q(per_q), .cnt(cnt), .wrap(wrap)
    );

    assign sample_evt = (cnt == ph_q);

    tmg_postscale #(.PW(PW)) u_post (
        .clk(clk), .rst(rst), .evt(sample_evt), .post_q(post_q), .irq_hit(irq_hit)
    );

    tmg_delay #(.DW(DW)) u_dly (
        .clk(clk), .rst(rst), .evt(sample_evt), .dly_q(dly_q), .done_hit(done_hit)
    );

    always_comb begin
        stb_d.sample = sample_evt;
        stb_d.irq    = irq_hit;
        stb_d.done   = done_hit;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stb_q <= TMG_STROBE_IDLE;
        else
            stb_q <= stb_d;
    end

    assign ramp_o          = cnt;
    assign sample_stb_o    = stb_q.sample;
    assign irq_stb_o       = stb_q.irq;
    assign task_done_stb_o = stb_q.done;
endmodule

// File: rtl/tmg_timebase_chk.sv
module tmg_timebase_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] ramp,
    input logic [CW-1:0] per_act,
    input logic          sample,
    input logic          irq,
    input logic          done
);
    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sample && !irq && !done && (ramp == '0)));

    // R5
    irq_in_sample_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> sample);

    // R1
    ramp_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        ramp < per_act);

    // R1
    ramp_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp != '0) |-> (ramp == $past(ramp) + CW'(1)));
endmodule

bind tmg_timebase tmg_timebase_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .ramp(ramp_o), .per_act(per_q),
    .sample(sample_stb_o), .irq(irq_stb_o), .done(task_done_stb_o)
);

// File: tb/tmg_timebase_tb.sv
module tmg_timebase_tb;
    localparam int CW = 8;
    localparam int PW = 4;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] cfg_period = 8'd4;
    logic [CW-1:0] cfg_phase  = 8'd0;
    logic [PW-1:0] cfg_post   = 4'd1;
    logic [DW-1:0] cfg_delay  = 8'd0;
    logic [CW-1:0] ramp_o;
    logic          sample_stb_o, irq_stb_o, task_done_stb_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tmg_timebase #(.CW(CW), .PW(PW), .DW(DW)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_period(cfg_period), .cfg_phase(cfg_phase),
        .cfg_post(cfg_post), .cfg_delay(cfg_delay),
        .ramp_o(ramp_o), .sample_stb_o(sample_stb_o),
        .irq_stb_o(irq_stb_o), .task_done_stb_o(task_done_stb_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Pulses reset; on return the bench sits at the falling edge of cycle 0
    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        // R9: outputs quiet while reset is held
        chk(ramp_o == 0 && !sample_stb_o && !irq_stb_o && !task_done_stb_o, "R9 reset",
            {ramp_o, sample_stb_o, irq_stb_o, task_done_stb_o}, 0);
        rst = 1'b0;
    endtask

    task automatic run_cfg(input int per, input int ph, input int post, input int dly);
        int pe, phe, ke, len;
        pe  = (per == 0) ? 1 : per;
        phe = (ph >= pe) ? pe - 1 : ph;
        ke  = (post == 0) ? 1 : post;
        cfg_period = CW'(per);
        cfg_phase  = CW'(ph);
        cfg_post   = PW'(post);
        cfg_delay  = DW'(dly);
        pulse_reset();
        len = pe * 3 * ke + dly + 6;
        for (int n = 0; n < len; n++) begin
            bit es, ei, ed;
            int k;
            es = (n >= 1) && (((n - 1) % pe) == phe);
            k  = es ? (n - 1 - phe) / pe : 0;
            ei = es && ((k % ke) == 0);
            ed = (dly < pe) && (n - dly >= 1) && (((n - 1 - dly) % pe) == phe);
            // R1: ramp value
            chk(int'(ramp_o) == n % pe, "R1 ramp", int'(ramp_o), n % pe);
            // R2 / R3: sample strobe position with clamped phase
            chk(sample_stb_o == es, (ph >= pe) ? "R3 sample clamp" : "R2 sample",
                int'(sample_stb_o), int'(es));
            // R4 / R5: interrupt decimation
            chk(irq_stb_o == ei, "R4 R5 irq", int'(irq_stb_o), int'(ei));
            // R6 / R7: end-of-task delay and restart
            chk(task_done_stb_o == ed, (dly >= pe) ? "R7 done restart" : "R6 done delay",
                int'(task_done_stb_o), int'(ed));
            @(negedge clk);
        end
    endtask

    task automatic deferred_change();
        int exp_seq[9] = '{2, 3, 0, 1, 2, 3, 4, 5, 0};
        cfg_period = 8'd4; cfg_phase = 8'd0; cfg_post = 4'd1; cfg_delay = 8'd0;
        pulse_reset();
        @(negedge clk);
        // cycle 1: ramp shows 1; change settings mid-ramp
        chk(ramp_o == 1, "R8 setup", int'(ramp_o), 1);
        cfg_period = 8'd6;
        cfg_phase  = 8'd3;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            // R8: old period finishes, new one starts after restart
            chk(int'(ramp_o) == exp_seq[i], "R8 deferred period", int'(ramp_o), exp_seq[i]);
            // R8: sample follows the new phase only after restart
            chk(sample_stb_o == (i == 6), "R8 deferred phase", int'(sample_stb_o), int'(i == 6));
        end
    endtask

    initial begin
        int pers[5] = '{0, 1, 2, 3, 5};
        int posts[4] = '{0, 1, 2, 3};
        foreach (pers[a]) begin
            int pe;
            pe = (pers[a] == 0) ? 1 : pers[a];
            for (int ph = 0; ph <= pe + 1; ph++) begin
                if (ph == pe) continue;
                foreach (posts[b]) begin
                    int dl[5];
                    dl = '{0, 1, pe - 1, pe, pe + 2};
                    foreach (dl[c])
                        run_cfg(pers[a], ph, posts[b], dl[c]);
                end
            end
        end
        deferred_change();
        // R9: reset applied mid-run silences everything
        cfg_period = 8'd3; cfg_phase = 8'd1; cfg_post = 4'd1; cfg_delay = 8'd0;
        pulse_reset();
        repeat (5) @(negedge clk);
        pulse_reset();
        chk(ramp_o == 0 && !sample_stb_o, "R9 first cycle after reset",
            int'(ramp_o), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule